// File: doc/BRIEF.md
# Masked Bit Scatter/Gather Unit

This unit moves bits between a source word and the positions selected by a mask. In scatter (deposit) mode, the low-order source bits are placed, in order, at the positions of the mask's set bits. In gather (extract) mode, the source bits found at the mask's set positions are packed, in order, into a contiguous field that starts at bit 0. Every other result bit is zero. Each operation works on either a 64-bit word or on the lower 32 bits of the word.

The unit is multi-cycle and does one set mask bit per cycle. On each step it finds the lowest remaining set bit with a trailing-zero count, moves one bit, and then drops that mask bit with `mask & (mask - 1)`. A start pulse captures the operands. After the last mask bit, one cycle is spent recognising the empty mask, and then `done_o` pulses. The result stays on `result_o` until the next start that is accepted. Flag generation and operand fetch belong to the surrounding datapath.

Top module: `pdx_unit`

## Requirements
- R1: While reset is asserted, and after it is released with no start, `result_o` is 0 and `done_o` is 0.
- R2: With `op_i`=0 (scatter), the result bit at the k-th lowest set mask position equals source bit k. Result bits where the mask is 0 are 0.
- R3: With `op_i`=1 (gather), result bit k equals the source bit at the k-th lowest set mask position. Result bits at and above the mask's population count are 0.
- R4: An all-zero effective mask gives a result of 0, with `done_o` high in the second cycle after the start edge.
- R5: `done_o` goes high exactly popcount(effective mask)+1 rising edges after the edge that accepts the start, and it stays high for one cycle only.
- R6: After `done_o`, `result_o` holds its value while no start is given, whatever happens on `op_i`, `wide_i`, `src_i` and `mask_i`.
- R7: A start given while an operation is running is ignored. The running operation keeps its operands, its result and its latency.
- R8: With `wide_i`=0, mask bits 63..32 are treated as 0, so the effective mask is `mask_i & 0xFFFFFFFF`. Result bits 63..32 are then 0. With `wide_i`=1, all 64 bits are used.
- R9: A start given in the cycle where `done_o` is high is accepted and runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; operands are captured when the unit is idle |
| op_i | input | 1 | 0 = scatter (deposit), 1 = gather (extract) |
| wide_i | input | 1 | 1 = 64-bit word, 0 = low 32 bits |
| src_i | input | 64 | Source word |
| mask_i | input | 64 | Selection mask |
| result_o | output | 64 | Result, valid from `done_o` until the next accepted start |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two events can share a cycle: the completion pulse of one operation and the start of the next. The bench runs every table vector back to back, raising `start_i` in the same cycle where it sees `done_o`. It accepts such a start only if the new result and the new latency both come out right. A start that arrives during a long all-ones operation must change neither the result nor the 65-cycle latency of that operation. The bench also checks that the completion pulse falls one cycle later.

// File: rtl/pdx_pkg.sv
package pdx_pkg;
  localparam int unsigned WORD_W   = 64;
  localparam int unsigned NARROW_W = 32;

  typedef enum logic {
    OP_SCATTER = 1'b0,
    OP_GATHER  = 1'b1
  } pdx_op_e;
endpackage

// File: rtl/pdx_tzc.sv
// Trailing-zero count: index of the lowest set bit.
module pdx_tzc #(
  parameter int unsigned W     = 64,
  localparam int unsigned IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     vec_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             zero_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign zero_o = (vec_i == '0);
endmodule

// File: rtl/pdx_ctrl.sv
module pdx_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic mask_empty_i,
  output logic busy_o,
  output logic load_o,
  output logic step_o,
  output logic done_o
);
  logic busy_q, done_q, finish;

  assign load_o = start_i & ~busy_q;
  assign step_o = busy_q & ~mask_empty_i;
  assign finish = busy_q & mask_empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (load_o)      busy_q <= 1'b1;
      else if (finish) busy_q <= 1'b0;
      done_q <= finish;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/pdx_core.sv
module pdx_core
  import pdx_pkg::*;
#(
  parameter int unsigned W     = WORD_W,
  parameter int unsigned N     = NARROW_W,
  localparam int unsigned IDX_W = $clog2(W),
  localparam int unsigned CNT_W = $clog2(W + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  pdx_op_e      op_i,
  input  logic         wide_i,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] mask_i,
  output logic         mask_empty_o,
  output logic [W-1:0] mask_o,
  output logic         wide_o,
  output logic [W-1:0] result_o
);
  localparam logic [W-1:0] NARROW_MASK = {{(W - N){1'b0}}, {N{1'b1}}};

  logic [W-1:0]     mask_q, src_q, res_q, lane_set;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] pos, dst, cnt_idx;
  pdx_op_e          op_q;
  logic             wide_q, moved_bit;

  pdx_tzc #(.W(W)) u_tzc (
    .vec_i (mask_q),
    .idx_o (pos),
    .zero_o(mask_empty_o)
  );

  assign cnt_idx   = cnt_q[IDX_W-1:0];
  assign moved_bit = (op_q == OP_SCATTER) ? src_q[cnt_idx] : src_q[pos];
  assign dst       = (op_q == OP_SCATTER) ? pos : cnt_idx;

  for (genvar g = 0; g < W; g++) begin : g_lane
    assign lane_set[g] = step_i & moved_bit & (dst == IDX_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      src_q  <= '0;
      res_q  <= '0;
      cnt_q  <= '0;
      op_q   <= OP_SCATTER;
      wide_q <= 1'b1;
    end else if (load_i) begin
      mask_q <= wide_i ? mask_i : (mask_i & NARROW_MASK);
      src_q  <= src_i;
      res_q  <= '0;
      cnt_q  <= '0;
      op_q   <= op_i;
      wide_q <= wide_i;
    end else if (step_i) begin
      mask_q <= mask_q & (mask_q - W'(1));
      res_q  <= res_q | lane_set;
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

  assign mask_o   = mask_q;
  assign wide_o   = wide_q;
  assign result_o = res_q;
endmodule

// File: rtl/pdx_unit.sv
module pdx_unit
  import pdx_pkg::*;
#(
  parameter int unsigned W = WORD_W,
  parameter int unsigned N = NARROW_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         op_i,
  input  logic         wide_i,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] result_o,
  output logic         done_o
);
  logic         busy, load, step, mask_empty, wide_q;
  logic [W-1:0] mask_q;

  pdx_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .mask_empty_i(mask_empty),
    .busy_o      (busy),
    .load_o      (load),
    .step_o      (step),
    .done_o      (done_o)
  );

  pdx_core #(.W(W), .N(N)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .step_i      (step),
    .op_i        (pdx_op_e'(op_i)),
    .wide_i      (wide_i),
    .src_i       (src_i),
    .mask_i      (mask_i),
    .mask_empty_o(mask_empty),
    .mask_o      (mask_q),
    .wide_o      (wide_q),
    .result_o    (result_o)
  );
endmodule

// File: rtl/pdx_unit_chk.sv
module pdx_unit_chk #(
  parameter int unsigned W = 64,
  parameter int unsigned N = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         done_o,
  input logic [W-1:0] result_o,
  input logic         busy,
  input logic [W-1:0] mask_q,
  input logic         wide_q
);
  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R5
  done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy));

  // R4
  empty_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && mask_q == '0) |=> (done_o && !busy));

  // R6
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !start_i) |=> $stable(result_o));

  // R7
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && start_i && mask_q != '0) |=> busy);

  // R8
  narrow_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wide_q |-> (result_o[W-1:N] == '0));
endmodule

bind pdx_unit pdx_unit_chk #(.W(W), .N(N)) u_pdx_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .done_o  (done_o),
  .result_o(result_o),
  .busy    (busy),
  .mask_q  (mask_q),
  .wide_q  (wide_q)
);

// File: tb/pdx_unit_test.sv
`timescale 1ns/1ps
module pdx_unit_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        op_i = 1'b0;
  logic        wide_i = 1'b1;
  logic [63:0] src_i = '0;
  logic [63:0] mask_i = '0;
  logic [63:0] result_o;
  logic        done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pdx_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
    .wide_i(wide_i), .src_i(src_i), .mask_i(mask_i),
    .result_o(result_o), .done_o(done_o)
  );

  typedef struct packed {
    logic        op;
    logic        wide;
    logic [63:0] src;
    logic [63:0] mask;
    logic [63:0] exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 64'h0000_0000_0000_00FF, 64'h0000_0000_0000_F0F0, 64'h0000_0000_0000_F0F0},
    '{1'b1, 1'b1, 64'h0000_0000_0000_F0F0, 64'h0000_0000_0000_FF00, 64'h0000_0000_0000_00F0},
    '{1'b0, 1'b1, 64'h0000_0000_0000_000A, 64'h8000_0000_0000_0011, 64'h0000_0000_0000_0010},
    '{1'b1, 1'b1, 64'h8000_0000_0000_0001, 64'h8000_0000_0000_0011, 64'h0000_0000_0000_0005},
    '{1'b0, 1'b1, 64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0},
    '{1'b1, 1'b1, 64'hDEAD_BEEF_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'hDEAD_BEEF_0000_0000},
    '{1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_0000_0000_000F, 64'h0000_0000_0000_000F},
    '{1'b1, 1'b0, 64'h0000_000F_8000_0000, 64'hFFFF_FFFF_8000_0000, 64'h0000_0000_0000_0001},
    '{1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000},
    '{1'b1, 1'b1, 64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0F0F, 64'h0000_0000_0000_000F}
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int eff_pop(input logic wide, input logic [63:0] mask);
    return $countones(wide ? mask : (mask & 64'h0000_0000_FFFF_FFFF));
  endfunction

  // Drive a start at a negedge, wait for done, return edges from accept to done.
  task automatic run_op(input logic op, input logic wide, input logic [63:0] src,
                        input logic [63:0] mask, output int lat);
    int n;
    op_i = op; wide_i = wide; src_i = src; mask_i = mask; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    n = 0;
    while (!done_o && n < 200) begin
      @(negedge clk);
      n++;
    end
    lat = n;
  endtask

  initial begin
    int lat, n;
    logic [63:0] held;
    // R1
    #1;
    chk(result_o == 64'h0 && done_o == 1'b0, "R1 in reset", {63'h0, done_o} | result_o, 64'h0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(result_o == 64'h0 && done_o == 1'b0, "R1 after release", {63'h0, done_o} | result_o, 64'h0);

    // table, back to back: each start raised in the done cycle of the previous (R9)
    for (int i = 0; i < NV; i++) begin
      run_op(VECS[i].op, VECS[i].wide, VECS[i].src, VECS[i].mask, lat);
      chk(result_o == VECS[i].exp,
          VECS[i].mask == 64'h0 ? "R4 zero mask result" :
          !VECS[i].wide ? "R8 narrow result" :
          VECS[i].op ? "R3 gather result" : "R2 scatter result",
          result_o, VECS[i].exp);
      chk(lat == eff_pop(VECS[i].wide, VECS[i].mask) + 1,
          i > 0 ? "R5 R9 latency" : "R5 latency",
          64'(lat), 64'(eff_pop(VECS[i].wide, VECS[i].mask) + 1));
    end
    @(negedge clk);
    chk(done_o == 1'b0, "R5 single-cycle done", {63'h0, done_o}, 64'h0);

    // R8: narrow scatter with upper mask bits set, upper result must be zero
    run_op(1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_0000_0001, lat);
    chk(result_o == 64'h1, "R8 upper mask ignored", result_o, 64'h1);
    chk(lat == 2, "R8 narrow latency", 64'(lat), 64'd2);

    // R4: zero mask latency with a gather
    @(negedge clk);
    run_op(1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, lat);
    chk(lat == 1 && result_o == 64'h0, "R4 zero mask latency", 64'(lat), 64'd1);

    // R6: hold after done with churning inputs
    run_op(1'b0, 1'b1, 64'h0000_0000_0000_0003, 64'h0000_0100_0000_0001, lat);
    held = result_o;
    chk(held == 64'h0000_0100_0000_0001, "R2 sparse scatter", held, 64'h0000_0100_0000_0001);
    for (int k = 0; k < 6; k++) begin
      op_i = ~op_i; wide_i = ~wide_i; src_i = ~src_i; mask_i = mask_i + 64'h1234_5;
      @(negedge clk);
      chk(result_o == held && !done_o, "R6 result held", result_o, held);
    end

    // R7: start during a long run is ignored
    op_i = 1'b0; wide_i = 1'b1; src_i = 64'hFFFF_FFFF_FFFF_FFFF;
    mask_i = 64'hFFFF_FFFF_FFFF_FFFF; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    n = 0;
    while (!done_o && n < 200) begin
      if (n == 5) begin
        op_i = 1'b1; src_i = 64'h0; mask_i = 64'h1; start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    start_i = 1'b0;
    chk(result_o == 64'hFFFF_FFFF_FFFF_FFFF, "R7 result unchanged", result_o,
        64'hFFFF_FFFF_FFFF_FFFF);
    chk(n == 65, "R7 latency unchanged", 64'(n), 64'd65);
    @(negedge clk);
    chk(done_o == 1'b0, "R7 no second done", {63'h0, done_o}, 64'h0);

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule